// File: doc/BRIEF.md
# Stepped Gain Ramp Attenuator

This block scales a set of signed 16-bit audio samples by a shared digital volume held in a 7-bit up/down counter. The gain applied to every channel is the counter value divided by 127, so a count of 127 passes samples unchanged and a count of 0 silences them completely.

The counter never jumps. Each time the effective target differs from the current count, the counter moves one step toward it, with one step taken per eight frame ticks. A full sweep across the range therefore takes about a thousand frames, in either direction. The effective target has three sources, in priority order. A soft-mute request forces it to zero. Otherwise a programmed 7-bit level applies when programming is enabled. Otherwise it is full scale.

After reset the count is zero, so the output fades in from silence. A settled flag reports when the count has reached the effective target. Samples arrive on a valid strobe that loads all channels at once. Each scaled result is registered and appears one clock later.

Top module: `gain_ramp_attenuator`

## Requirements
- R1: While reset is held and on the first cycle after it, gain_lvl is 0, every channel of smp_out is 0 and out_vld is 0.
- R2: With mute_req=0 and prog_en=0 the effective target is 127, so after reset the count climbs from 0 to 127 and then holds there.
- R3: One clock after smp_vld is high, out_vld is high and each 16-bit channel field of smp_out equals the sample in the same field of smp_in times gain_lvl, divided by 127 and truncated toward zero. Channel k occupies bits [16k+15:16k], and all channels use the same count. The result never exceeds the input in magnitude.
- R4: A sample taken while gain_lvl is 0 yields an output of exactly 0.
- R5: The count changes only on a frame_tick and only by one step toward the effective target. Ticks are counted only while the count differs from the target; the step falls on the 8th such tick, and the tick count then restarts from zero.
- R6: With mute_req=1 the effective target is 0, whatever the other inputs are. Releasing mute ramps the count back up at the same rate of one step per 8 ticks.
- R7: With mute_req=0 and prog_en=1 the effective target is atten_lvl. If the target changes mid-ramp, the ramp turns toward the new value without losing its tick count.
- R8: settled is high exactly when gain_lvl equals the effective target. A tick taken while settled clears the tick count, so a later target change steps on its 8th tick.
- R9: At a count of 127, every output sample equals its input sample, including -32768 and 32767.
- R10: While smp_vld is low, out_vld is 0 and smp_out holds its last value, even across gain steps and changes on smp_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse once per frame period |
| mute_req | input | 1 | Soft-mute request; ramps the gain to zero |
| prog_en | input | 1 | Use the programmed level as the unmuted target |
| atten_lvl | input | 7 | Programmed gain level (0 silent, 127 unity) |
| smp_vld | input | 1 | Loads all channel samples this cycle |
| smp_in | input | 32 | Signed 16-bit samples, channel k at bits [16k+15:16k] |
| out_vld | output | 1 | Scaled samples updated on the previous edge |
| smp_out | output | 32 | Scaled signed samples, same packing as smp_in |
| gain_lvl | output | 7 | Current ramp count |
| settled | output | 1 | Count equals the effective target |

## Verification
A scaled sample is due one clock after its smp_vld edge, so the bench raises the strobe at a falling edge and checks out_vld and smp_out at the next falling edge. It computes the expected values from its own model of the count. A gain step lands on the rising edge that carries the qualifying frame_tick, so after every tick the bench checks gain_lvl at the following falling edge against a step-and-tick-count model. settled depends only on that count and on the current inputs, so it is checked in the same cycle. Samples are never strobed on a tick cycle, which keeps the count each sample sees unambiguous.

// File: rtl/gain_ramp_pkg.sv
// Shared sizing defaults for the stepped gain ramp attenuator.
// Assumes: gain levels are unsigned, samples are two's complement.
package gain_ramp_pkg;
    localparam int SAMPLE_W_DEF = 16;
    localparam int GAIN_W_DEF   = 7;
    localparam int CHANNELS_DEF = 2;
    localparam int TICKS_DEF    = 8;
endpackage

// File: rtl/gain_target_sel.sv
// Picks the level the gain ramp is heading to.
// Priority: mute (zero) over programmed level over full scale.
// Assumes: inputs are synchronous to the ramp clock.
module gain_target_sel #(
    parameter int GAIN_W = 7
) (
    input  logic              mute_req,
    input  logic              prog_en,
    input  logic [GAIN_W-1:0] atten_lvl,
    output logic [GAIN_W-1:0] target
);
    localparam logic [GAIN_W-1:0] FULL_LVL = '1;

    // Resolve the effective target by priority.
    always_comb begin
        if (mute_req)
            target = '0;
        else if (prog_en)
            target = atten_lvl;
        else
            target = FULL_LVL;
    end
endmodule

// File: rtl/gain_ramp_ctr.sv
// Up/down gain counter that moves one step toward its target after
// TICKS_PER_STEP frame ticks taken while unsettled.
// Assumes: frame_tick is a one-cycle pulse; reset is synchronous active-low.
module gain_ramp_ctr #(
    parameter int GAIN_W         = 7,
    parameter int TICKS_PER_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic [GAIN_W-1:0] target,
    output logic [GAIN_W-1:0] cnt_q,
    output logic              settled
);
    localparam int DIV_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS_PER_STEP - 1);

    logic [DIV_W-1:0] div_q;
    logic             step_en;

    // Settled when the count has reached the target.
    always_comb settled = (cnt_q == target);

    // A step is due on the last tick of the prescale window.
    always_comb step_en = frame_tick && !settled && (div_q == DIV_LAST);

    // Tick prescaler: counts ticks while unsettled, clears on a settled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (frame_tick) begin
            if (settled || div_q == DIV_LAST)
                div_q <= '0;
            else
                div_q <= div_q + DIV_W'(1);
        end
    end

    // Gain counter: one step toward the target per prescale window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step_en) begin
            if (cnt_q < target)
                cnt_q <= cnt_q + GAIN_W'(1);
            else
                cnt_q <= cnt_q - GAIN_W'(1);
        end
    end

    // R5
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |->
        (cnt_q == $past(cnt_q) + GAIN_W'(1) || cnt_q == $past(cnt_q) - GAIN_W'(1)));

    // R5
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> $past(frame_tick));

    // R6
    step_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |->
        ((cnt_q > $past(cnt_q)) == ($past(target) > $past(cnt_q))));

    // R8
    settled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(settled) && $stable(target)) |-> $stable(cnt_q));
endmodule

// File: rtl/gain_scaler.sv
// Scales one signed sample by gain/FULL, truncating toward zero,
// and registers the result when load is high.
// Assumes: gain never exceeds FULL, so the result cannot overflow.
module gain_scaler #(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic        [GAIN_W-1:0]   gain,
    input  logic signed [SAMPLE_W-1:0] din,
    output logic signed [SAMPLE_W-1:0] dout
);
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] DIVISOR = PROD_W'((1 << GAIN_W) - 1);

    logic signed [PROD_W-1:0] din_ext, gain_ext, prod, quot;

    // Widen, multiply and divide with truncation toward zero.
    always_comb begin
        din_ext  = PROD_W'(din);
        gain_ext = PROD_W'({1'b0, gain});
        prod     = din_ext * gain_ext;
        quot     = prod / DIVISOR;
    end

    // Output register, loaded on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= quot[SAMPLE_W-1:0];
    end

    // R4
    zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && gain == '0) |=> (dout == '0));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && din >= 0) |=> (dout >= 0 && dout <= $past(din)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/gain_ramp_attenuator.sv
// Multi-channel stepped attenuator: a shared ramped gain count scales
// every channel's sample on each strobe; the result follows one clock later.
// Assumes: synchronous active-low reset; frame_tick one cycle per frame.
module gain_ramp_attenuator
    import gain_ramp_pkg::*;
#(
    parameter int SAMPLE_W       = SAMPLE_W_DEF,
    parameter int GAIN_W         = GAIN_W_DEF,
    parameter int CHANNELS       = CHANNELS_DEF,
    parameter int TICKS_PER_STEP = TICKS_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_tick,
    input  logic                         mute_req,
    input  logic                         prog_en,
    input  logic [GAIN_W-1:0]            atten_lvl,
    input  logic                         smp_vld,
    input  logic [CHANNELS*SAMPLE_W-1:0] smp_in,
    output logic                         out_vld,
    output logic [CHANNELS*SAMPLE_W-1:0] smp_out,
    output logic [GAIN_W-1:0]            gain_lvl,
    output logic                         settled
);
    logic [GAIN_W-1:0] target;

    gain_target_sel #(.GAIN_W(GAIN_W)) u_target (
        .mute_req  (mute_req),
        .prog_en   (prog_en),
        .atten_lvl (atten_lvl),
        .target    (target)
    );

    gain_ramp_ctr #(.GAIN_W(GAIN_W), .TICKS_PER_STEP(TICKS_PER_STEP)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .target     (target),
        .cnt_q      (gain_lvl),
        .settled    (settled)
    );

    // One scaler per channel, all sharing the ramp count.
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : gen_ch
        logic signed [SAMPLE_W-1:0] ch_in, ch_out;
        always_comb ch_in = smp_in[ch*SAMPLE_W +: SAMPLE_W];
        always_comb smp_out[ch*SAMPLE_W +: SAMPLE_W] = ch_out;

        gain_scaler #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (smp_vld),
            .gain  (gain_lvl),
            .din   (ch_in),
            .dout  (ch_out)
        );
    end

    // Output strobe, one clock behind the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_vld <= 1'b0;
        else
            out_vld <= smp_vld;
    end

    // R3
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> out_vld);

    // R6
    mute_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_req && settled) |-> (gain_lvl == '0));
endmodule

// File: tb/gain_ramp_attenuator_bench.sv
module gain_ramp_attenuator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic        mute_req = 1'b0;
    logic        prog_en = 1'b0;
    logic [6:0]  atten_lvl = '0;
    logic        smp_vld = 1'b0;
    logic [31:0] smp_in = '0;
    logic        out_vld;
    logic [31:0] smp_out;
    logic [6:0]  gain_lvl;
    logic        settled;

    int errs = 0;
    int checks = 0;
    int m_cnt = 0;
    int m_div = 0;
    int seed_init;

    always #10 clk = ~clk;

    gain_ramp_attenuator u_gain_ramp_attenuator (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mute_req(mute_req),
        .prog_en(prog_en), .atten_lvl(atten_lvl), .smp_vld(smp_vld),
        .smp_in(smp_in), .out_vld(out_vld), .smp_out(smp_out),
        .gain_lvl(gain_lvl), .settled(settled)
    );

    function automatic int eff_tgt();
        if (mute_req) return 0;
        if (prog_en) return int'(atten_lvl);
        return 127;
    endfunction

    function automatic int scale(int s, int g);
        return (s * g) / 127;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(string req);
        int t;
        @(negedge clk);
        frame_tick = 1'b1;
        t = eff_tgt();
        if (m_cnt != t) begin
            if (m_div == 7) begin
                m_cnt += (m_cnt < t) ? 1 : -1;
                m_div = 0;
            end else m_div++;
        end else m_div = 0;
        @(negedge clk);
        frame_tick = 1'b0;
        chk(req, int'(gain_lvl), m_cnt);
    endtask

    task automatic samp(string req, int l, int r);
        @(negedge clk);
        smp_vld = 1'b1;
        smp_in = {16'(r), 16'(l)};
        @(negedge clk);
        smp_vld = 1'b0;
        chk(req, int'(out_vld), 1);
        chk(req, int'($signed(smp_out[15:0])), scale(l, m_cnt));
        chk(req, int'($signed(smp_out[31:16])), scale(r, m_cnt));
    endtask

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    task automatic ramp_until_settled(string req);
        int guard = 0;
        while (m_cnt != eff_tgt() && guard < 1200) begin
            tick(req);
            guard++;
            if (guard % 37 == 0) samp(req, rnd16(), rnd16());
        end
        chk(req, int'(settled), 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        int hold_l, hold_r;
        seed_init = $urandom(32'h5eed1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cnt", int'(gain_lvl), 0);
        chk("R1 out", int'(smp_out), 0);
        chk("R1 vld", int'(out_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cnt after", int'(gain_lvl), 0);
        chk("R1 vld after", int'(out_vld), 0);
        // R4: zero gain silences
        samp("R4", -32768, 32767);
        samp("R4", rnd16(), rnd16());
        // R5: first step on the 8th tick
        for (int i = 0; i < 7; i++) tick("R5 pre");
        chk("R5 still0", int'(gain_lvl), 0);
        chk("R8 unsettled", int'(settled), 0);
        tick("R5 first");
        chk("R5 one", int'(gain_lvl), 1);
        // R2: climb to full scale
        ramp_until_settled("R2");
        chk("R2 full", int'(gain_lvl), 127);
        for (int i = 0; i < 20; i++) tick("R2 hold");
        // R9: unity at full scale
        samp("R9", -32768, 32767);
        samp("R9", -1, 1);
        for (int i = 0; i < 6; i++) samp("R9", rnd16(), rnd16());
        // R7: programmed level
        prog_en = 1'b1;
        atten_lvl = 7'd64;
        @(negedge clk);
        chk("R8 leave", int'(settled), 0);
        for (int i = 0; i < 7; i++) tick("R8 window");
        chk("R8 no early", int'(gain_lvl), 127);
        tick("R8 eighth");
        ramp_until_settled("R7");
        samp("R3", -32768, 32767);
        for (int i = 0; i < 8; i++) samp("R3", rnd16(), rnd16());
        // R7: reverse mid-ramp
        atten_lvl = 7'd40;
        for (int i = 0; i < 45; i++) tick("R7 down");
        atten_lvl = 7'd100;
        ramp_until_settled("R7 reverse");
        // R10: hold without strobe
        samp("R10 base", 1234, -4321);
        hold_l = int'($signed(smp_out[15:0]));
        hold_r = int'($signed(smp_out[31:16]));
        atten_lvl = 7'd90;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            smp_in = {16'($urandom), 16'($urandom)};
            tick("R10 tick");
            chk("R10 vld", int'(out_vld), 0);
            chk("R10 l", int'($signed(smp_out[15:0])), hold_l);
            chk("R10 r", int'($signed(smp_out[31:16])), hold_r);
        end
        // R6: mute down to zero, release back up
        mute_req = 1'b1;
        prog_en = 1'b0;
        ramp_until_settled("R6 mute");
        chk("R6 zero", int'(gain_lvl), 0);
        samp("R4 muted", rnd16(), rnd16());
        mute_req = 1'b0;
        for (int i = 0; i < 8; i++) tick("R6 release");
        chk("R6 rate", int'(gain_lvl), 1);
        ramp_until_settled("R6 up");
        chk("R6 full", int'(gain_lvl), 127);
        // R3: random mix at random programmed levels
        prog_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            atten_lvl = 7'($urandom);
            ramp_until_settled("R3 lvl");
            for (int i = 0; i < 4; i++) samp("R3 rnd", rnd16(), rnd16());
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule